// File: doc/BRIEF.md
# Paged Operand Address Sequencer

This block forms operand addresses and paces memory cycles for a machine with a 16-bit instruction word and a 15-bit word address. An instruction is handed to it once its fetch cycle completes. The block splits the word into a function code, an index selector, a page-select bit and an 8-bit operand field. The 8-bit field reaches only 256 words, so a 7-bit page register supplies the upper address bits whenever the page-select bit is set. A dedicated load-page function writes that register.

When an index selector is non-zero, the block spends one extra memory cycle reading the index word from a fixed low address. It adds that word to the base address before it issues the operand access. Every request the block issues is registered. When an instruction finishes, the block reports how many memory cycles it used, counting the fetch. It accepts no new instruction until the last cycle of the current one is done.

Top module: `ext_addr_seq`

## Requirements
- R1: After reset, or a reset applied in the middle of an instruction, instr_ready is 1, mem_req is 0, done_valid is 0 and the page register is 0.
- R2: The instruction word is split as function = bits [15:11], index select = bits [10:9], page select = bit [8] and operand = bits [7:0].
- R3: With page select 0, the base address is the operand zero-extended to 15 bits.
- R4: With page select 1, the base address is {page register, operand}.
- R5: Function code 28 (octal 34) loads operand bits [6:0] into the page register, whatever the index and page-select bits hold. It issues no memory request and reports 1 cycle.
- R6: Any other function with index select 0 raises mem_req for exactly one cycle at the base address, in the cycle after acceptance, and reports 2 cycles.
- R7: Any other function with index select n in 1..3 first requests address n for one cycle. It then requests base + mem_rdata[14:0] for one cycle and reports 3 cycles.
- R8: The indexed address wraps modulo 2^15.
- R9: instr_ready is 0 from acceptance until the last memory cycle completes. An instr_valid seen while instr_ready is 0 is ignored.
- R10: done_valid is a single-cycle pulse in the cycle after the final cycle. cycles_taken holds the count while done_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Fetched instruction present |
| instr_word | input | 16 | Fetched instruction |
| instr_ready | output | 1 | Sequencer idle; instruction taken when instr_valid is also 1 |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 15 | Memory word address |
| mem_rdata | input | 16 | Read data, valid in the same cycle as mem_req |
| done_valid | output | 1 | Instruction finished |
| cycles_taken | output | 2 | Memory cycles used, including the fetch |

## Verification
The properties assume that memory returns read data combinationally within the cycle in which mem_req is high. They also assume that instr_word is stable in the cycle it is offered. The bench meets both conditions. Its memory model is a pure function of mem_addr, and it drives instr_valid and instr_word only at the falling edge, holding them for one full cycle. A word offered while the sequencer is busy is deliberately injected to exercise the ignore rule.

// File: rtl/ext_seq_pkg.sv
package ext_seq_pkg;
  localparam int WORD_W_D = 16;
  localparam int ADDR_W_D = 15;
  localparam int OPND_W_D = 8;
  localparam int FUNC_W_D = 5;
  localparam int BSEL_W_D = 2;
  localparam int PAGE_LOAD_CODE = 28;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_INDEX = 2'd1,
    SQ_OPND  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/instr_split.sv
module instr_split #(
  parameter int WORD_W = 16,
  parameter int FUNC_W = 5,
  parameter int BSEL_W = 2,
  parameter int OPND_W = 8,
  parameter int LOAD_CODE = 28
) (
  input  logic [WORD_W-1:0] word,
  output logic [BSEL_W-1:0] bsel,
  output logic              page_sel,
  output logic [OPND_W-1:0] opnd,
  output logic              is_page_load,
  output logic              is_indexed
);
  localparam int FUNC_LSB = WORD_W - FUNC_W;
  localparam int BSEL_LSB = FUNC_LSB - BSEL_W;
  localparam int PSEL_POS = BSEL_LSB - 1;

  logic [FUNC_W-1:0] func;

  always_comb begin
    func         = word[WORD_W-1:FUNC_LSB];
    bsel         = word[FUNC_LSB-1:BSEL_LSB];
    page_sel     = word[PSEL_POS];
    opnd         = word[OPND_W-1:0];
    is_page_load = (func == FUNC_W'(LOAD_CODE));
    is_indexed   = (bsel != '0);
  end
endmodule

// File: rtl/page_addr_unit.sv
module page_addr_unit #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 15,
  parameter int OPND_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              page_load,
  input  logic              page_sel,
  input  logic [OPND_W-1:0] opnd,
  input  logic [ADDR_W-1:0] base_hold,
  input  logic [WORD_W-1:0] index_word,
  output logic [ADDR_W-1:0] base_addr,
  output logic [ADDR_W-1:0] indexed_addr
);
  localparam int PAGE_W = ADDR_W - OPND_W;

  logic [PAGE_W-1:0] page_q;
  logic              unused_bits;

  always_ff @(posedge clk) begin
    if (rst) page_q <= '0;
    else if (page_load) page_q <= opnd[PAGE_W-1:0];
  end

  always_comb begin
    base_addr    = page_sel ? {page_q, opnd} : {{PAGE_W{1'b0}}, opnd};
    indexed_addr = base_hold + index_word[ADDR_W-1:0];
  end

  assign unused_bits = ^{index_word[WORD_W-1:ADDR_W], opnd[OPND_W-1:PAGE_W]};
endmodule

// File: rtl/cycle_pacer.sv
module cycle_pacer
  import ext_seq_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int BSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              is_page_load,
  input  logic              is_indexed,
  input  logic [BSEL_W-1:0] bsel,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] indexed_addr,
  output logic [ADDR_W-1:0] base_hold,
  output logic              idle,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              done_valid,
  output logic [1:0]        cycles_taken
);
  seq_state_t state;
  logic       indexed_q;

  assign idle = (state == SQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= SQ_IDLE;
      indexed_q    <= 1'b0;
      base_hold    <= '0;
      mem_req      <= 1'b0;
      mem_addr     <= '0;
      done_valid   <= 1'b0;
      cycles_taken <= 2'd0;
    end else begin
      done_valid <= 1'b0;
      unique case (state)
        SQ_IDLE: if (take) begin
          if (is_page_load) begin
            done_valid   <= 1'b1;
            cycles_taken <= 2'd1;
          end else begin
            base_hold <= base_addr;
            indexed_q <= is_indexed;
            mem_req   <= 1'b1;
            if (is_indexed) begin
              state    <= SQ_INDEX;
              mem_addr <= {{(ADDR_W-BSEL_W){1'b0}}, bsel};
            end else begin
              state    <= SQ_OPND;
              mem_addr <= base_addr;
            end
          end
        end
        SQ_INDEX: begin
          state    <= SQ_OPND;
          mem_addr <= indexed_addr;
        end
        SQ_OPND: begin
          state        <= SQ_IDLE;
          mem_req      <= 1'b0;
          done_valid   <= 1'b1;
          cycles_taken <= indexed_q ? 2'd3 : 2'd2;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ext_addr_seq.sv
module ext_addr_seq
  import ext_seq_pkg::*;
#(
  parameter int WORD_W = WORD_W_D,
  parameter int ADDR_W = ADDR_W_D,
  parameter int OPND_W = OPND_W_D,
  parameter int FUNC_W = FUNC_W_D,
  parameter int BSEL_W = BSEL_W_D,
  parameter int LOAD_CODE = PAGE_LOAD_CODE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [WORD_W-1:0] instr_word,
  output logic              instr_ready,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              done_valid,
  output logic [1:0]        cycles_taken
);
  logic [BSEL_W-1:0] bsel;
  logic              page_sel, is_page_load, is_indexed, take;
  logic [OPND_W-1:0] opnd;
  logic [ADDR_W-1:0] base_addr, indexed_addr, base_hold;

  assign take = instr_valid && instr_ready;

  instr_split #(
    .WORD_W(WORD_W), .FUNC_W(FUNC_W), .BSEL_W(BSEL_W),
    .OPND_W(OPND_W), .LOAD_CODE(LOAD_CODE)
  ) u_split (
    .word(instr_word), .bsel(bsel), .page_sel(page_sel), .opnd(opnd),
    .is_page_load(is_page_load), .is_indexed(is_indexed)
  );

  page_addr_unit #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .OPND_W(OPND_W)) u_addr (
    .clk(clk), .rst(rst), .page_load(take && is_page_load),
    .page_sel(page_sel), .opnd(opnd), .base_hold(base_hold),
    .index_word(mem_rdata), .base_addr(base_addr), .indexed_addr(indexed_addr)
  );

  cycle_pacer #(.ADDR_W(ADDR_W), .BSEL_W(BSEL_W)) u_pace (
    .clk(clk), .rst(rst), .take(take), .is_page_load(is_page_load),
    .is_indexed(is_indexed), .bsel(bsel), .base_addr(base_addr),
    .indexed_addr(indexed_addr), .base_hold(base_hold), .idle(instr_ready),
    .mem_req(mem_req), .mem_addr(mem_addr), .done_valid(done_valid),
    .cycles_taken(cycles_taken)
  );
endmodule

// File: rtl/ext_addr_seq_chk.sv
module ext_addr_seq_chk #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 15,
  parameter int OPND_W = 8,
  parameter int FUNC_W = 5,
  parameter int BSEL_W = 2,
  parameter int LOAD_CODE = 28
) (
  input logic              clk,
  input logic              rst,
  input logic              instr_valid,
  input logic [WORD_W-1:0] instr_word,
  input logic              instr_ready,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              done_valid,
  input logic [1:0]        cycles_taken
);
  localparam int FLSB = WORD_W - FUNC_W;
  localparam int BLSB = FLSB - BSEL_W;
  localparam int PAGE_W = ADDR_W - OPND_W;

  logic acc, acc_load, acc_plain, acc_idx;
  assign acc       = instr_valid && instr_ready;
  assign acc_load  = acc && (instr_word[WORD_W-1:FLSB] == FUNC_W'(LOAD_CODE));
  assign acc_plain = acc && !acc_load && (instr_word[FLSB-1:BLSB] == '0);
  assign acc_idx   = acc && !acc_load && (instr_word[FLSB-1:BLSB] != '0);

  // R9
  req_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !instr_ready);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid);
  // R10
  done_count_range_chk: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> (cycles_taken != 2'd0));
  // R5
  page_load_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    acc_load |=> (done_valid && cycles_taken == 2'd1 && !mem_req));
  // R3
  plain_low_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_plain && !instr_word[BLSB-1]) |=>
      (mem_req && mem_addr == {{PAGE_W{1'b0}}, $past(instr_word[OPND_W-1:0])}));
  // R7
  index_first_addr_chk: assert property (@(posedge clk) disable iff (rst)
    acc_idx |=> (mem_req && mem_addr == ADDR_W'($past(instr_word[FLSB-1:BLSB]))));
  // R6
  plain_then_done_chk: assert property (@(posedge clk) disable iff (rst)
    acc_plain |=> ##1 (done_valid && cycles_taken == 2'd2 && !mem_req));
endmodule

bind ext_addr_seq ext_addr_seq_chk #(
  .WORD_W(WORD_W), .ADDR_W(ADDR_W), .OPND_W(OPND_W),
  .FUNC_W(FUNC_W), .BSEL_W(BSEL_W), .LOAD_CODE(LOAD_CODE)
) u_chk (
  .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
  .instr_ready(instr_ready), .mem_req(mem_req), .mem_addr(mem_addr),
  .done_valid(done_valid), .cycles_taken(cycles_taken)
);

// File: tb/ext_addr_seq_tb.sv
module ext_addr_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [15:0] instr_word = '0;
  logic        instr_ready, mem_req, done_valid;
  logic [14:0] mem_addr;
  logic [15:0] mem_rdata;
  logic [1:0]  cycles_taken;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  ext_addr_seq u_dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .instr_ready(instr_ready), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .done_valid(done_valid), .cycles_taken(cycles_taken)
  );

  // index words at fixed addresses 1..3; bit 15 set on address 1 must be ignored
  always_comb begin
    case (mem_addr)
      15'd1:   mem_rdata = 16'h8010;
      15'd2:   mem_rdata = 16'h7FF0;
      15'd3:   mem_rdata = 16'h0100;
      default: mem_rdata = 16'h1234;
    endcase
  end

  // {word, cycles, first request address, last request address}
  localparam int NV = 11;
  localparam logic [47:0] VEC [NV] = '{
    {16'h0925, 2'd2, 15'h0025, 15'h0025},  // R4 page 0 after reset
    {16'hE07A, 2'd1, 15'h0000, 15'h0000},  // R5 load page 7A
    {16'h0925, 2'd2, 15'h7A25, 15'h7A25},  // R4
    {16'h0825, 2'd2, 15'h0025, 15'h0025},  // R3
    {16'h1340, 2'd3, 15'h0001, 15'h7A50},  // R7
    {16'h1520, 2'd3, 15'h0002, 15'h7A10},  // R8 wrap
    {16'hE0FF, 2'd1, 15'h0000, 15'h0000},  // R5 bit 7 dropped
    {16'h1D30, 2'd3, 15'h0002, 15'h7F20},  // R8
    {16'h1EFF, 2'd3, 15'h0003, 15'h01FF},  // R7 R3
    {16'hE701, 2'd1, 15'h0000, 15'h0000},  // R5 index/page bits ignored
    {16'hF980, 2'd2, 15'h0180, 15'h0180}   // R2 R6 top function code
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] w, output int ncyc, output int nreq,
                     output logic [14:0] a_first, output logic [14:0] a_last);
    ncyc = 0; nreq = 0; a_first = '0; a_last = '0;
    while (!instr_ready) @(negedge clk);
    instr_valid = 1'b1; instr_word = w;
    @(negedge clk);
    instr_valid = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (mem_req) begin
        if (nreq == 0) a_first = mem_addr;
        a_last = mem_addr;
        nreq++;
      end
      if (done_valid) begin
        ncyc = cycles_taken;
        break;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int nc, nr;
    logic [14:0] af, al;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(instr_ready === 1'b1, "R1 ready", instr_ready, 1);
    chk(mem_req === 1'b0, "R1 req", mem_req, 0);
    chk(done_valid === 1'b0, "R1 done", done_valid, 0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] ec;
      ec = VEC[i][31:30];
      run(VEC[i][47:32], nc, nr, af, al);
      chk(nc == int'(ec), $sformatf("R10 cycles vec%0d", i), nc, ec);
      chk(nr == int'(ec) - 1, $sformatf("R6 R7 requests vec%0d", i), nr, ec - 1);
      if (nr > 0) begin
        chk(af == VEC[i][29:15], $sformatf("R7 first addr vec%0d", i), af, VEC[i][29:15]);
        chk(al == VEC[i][14:0], $sformatf("R2 R4 last addr vec%0d", i), al, VEC[i][14:0]);
      end
      @(negedge clk);
      chk(done_valid === 1'b0, $sformatf("R10 pulse vec%0d", i), done_valid, 0);
    end

    // R9: page load offered while busy must be ignored (page register is 1 here)
    instr_valid = 1'b1; instr_word = 16'h1340;
    @(negedge clk);
    instr_word = 16'hE055;
    chk(instr_ready === 1'b0, "R9 busy after accept", instr_ready, 0);
    chk(mem_addr == 15'h0001, "R7 index addr", mem_addr, 1);
    @(negedge clk);
    instr_valid = 1'b0;
    chk(instr_ready === 1'b0, "R9 busy operand cycle", instr_ready, 0);
    chk(mem_addr == 15'h0150, "R7 operand addr", mem_addr, 15'h0150);
    @(negedge clk);
    chk(done_valid && cycles_taken == 2'd3, "R10 busy done", cycles_taken, 3);
    run(16'h0900, nc, nr, af, al);
    chk(al == 15'h0100, "R9 page unchanged", al, 15'h0100);

    // R1: reset in the middle of an indexed instruction
    @(negedge clk);
    instr_valid = 1'b1; instr_word = 16'h1340;
    @(negedge clk);
    instr_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk(instr_ready === 1'b1 && mem_req === 1'b0 && done_valid === 1'b0,
        "R1 mid reset", {instr_ready, mem_req, done_valid}, 3'b100);
    rst = 1'b0;
    @(negedge clk);
    run(16'h0900, nc, nr, af, al);
    chk(al == 15'h0000, "R1 page cleared", al, 0);
    chk(nc == 2, "R6 after reset", nc, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule